// File: doc/BRIEF.md
# Host-to-Local Mailbox Register Bridge

This block lets a PC-style host on an I/O bus and a local embedded processor swap bytes through a small set of shared registers. The host finds the block at a base address on its address bits 9:2. That base comes in on an input, driven by a register elsewhere in the chip. Host address bits 1:0 pick one of four slots: a host-to-local byte, a register pair (host-to-local on write, local-to-host on read), a status byte and an auxiliary write-only latch.

Each mailbox byte has a data-available flag. One side sets the flag by writing the byte, and the other side clears it by reading the byte. A master enable bit in the status byte is writable only by the local processor. While that bit is low, the host cannot reach the block, and the local processor can change nothing but the enable bit. The host strobes are asynchronous to the local clock, so each one is synchronized and turned into a single action.

Top module: `host_mailbox`

## Requirements
- R1: After reset, every mailbox byte, the auxiliary latch, every flag, the scratch bits and the enable bit are 0.
- R2: A host access takes effect only when h_addr[9:2] equals base_addr, h_aen_n is 0 and h_rd_n or h_wr_n is 0. A mismatched or unqualified access changes nothing, and h_rdata reads 0 outside a decoded host read.
- R3: A host write with h_addr[1:0]=00 loads output byte 0 and sets status bit 1. A local read at offset 0x3 returns that byte and clears status bit 1. A host read at 00 also returns output byte 0.
- R4: A host write with h_addr[1:0]=01 loads output byte 1 and sets status bit 2. A local read at offset 0x4 returns that byte and clears status bit 2.
- R5: A local write at offset 0x4 loads input byte 1 and sets status bit 3. A host read with h_addr[1:0]=01 returns that byte and clears status bit 3.
- R6: The status byte holds: bit 7 = enable, bits 6:4 = scratch, bit 3 = input-1 flag, bit 2 = output-1 flag, bit 1 = output-0 flag, bit 0 = 0. The local side reads it at offset 0x5 and the host reads it at h_addr[1:0]=10. A host write at 10 has no effect.
- R7: A host write with h_addr[1:0]=11 loads the auxiliary latch (aux_out) only while dma_mbox_en is 0. A host read at 11 returns 0 and has no side effect.
- R8: While the enable bit is 0: host accesses are ignored; local reads at 0x3, 0x4 and 0x5 return 0 and clear nothing; a local write at 0x4 is ignored; a local write at 0x5 changes only bit 7. No flag can become set.
- R9: One host strobe assertion, however long, causes exactly one register action. When a set and a clear of the same flag land in the same local clock cycle, the flag ends up set.
- R10: While enabled, a local write at 0x5 updates bits 7 and 6:4 and leaves bits 3:0 unchanged. Local reads at other offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| base_addr | input | 8 | Host base address compared with h_addr[9:2] |
| dma_mbox_en | input | 1 | When 1, host writes to slot 11 are not latched |
| h_addr | input | 10 | Host address |
| h_aen_n | input | 1 | Host address enable, active low |
| h_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| h_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, 0 when not selected |
| l_addr | input | 4 | Local register offset |
| l_rd | input | 1 | Local read, one cycle per access |
| l_wr | input | 1 | Local write, one cycle per access |
| l_wdata | input | 8 | Local write data |
| l_rdata | output | 8 | Local read data |
| aux_out | output | 8 | Auxiliary latch contents |

## Verification
The hardest case to reach is a flag being set and cleared in the same local cycle. One of the two events comes from a host strobe that only acts after passing through the synchronizer. The bench asserts the host read strobe half a cycle after a clock edge and counts the synchronizer edges. It then drives the local write to offset 0x4 in exactly the cycle where the host read pulse appears, and checks that status bit 3 stays set. A second directed case holds a host write strobe low across many cycles and clears the flag locally in the middle of it, to show that no second action follows.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int DW      = 8;
    localparam int HOST_AW = 10;
    localparam int BASE_W  = HOST_AW - 2;
    localparam int LOC_AW  = 4;

    typedef enum logic [1:0] {
        HSEL_OUT0  = 2'b00,
        HSEL_PAIR1 = 2'b01,
        HSEL_STAT  = 2'b10,
        HSEL_AUX   = 2'b11
    } hsel_e;

    localparam logic [LOC_AW-1:0] LOFF_OUT0  = 4'h3;
    localparam logic [LOC_AW-1:0] LOFF_PAIR1 = 4'h4;
    localparam logic [LOC_AW-1:0] LOFF_STAT  = 4'h5;

    typedef struct packed {
        logic       en;
        logic [2:0] scratch;
        logic       in1_dav;
        logic       out1_dav;
        logic       out0_dav;
        logic       rsvd;
    } status_t;

    // set has priority over clear
    function automatic logic flag_upd(input logic cur, input logic set, input logic clr);
        return set ? 1'b1 : (clr ? 1'b0 : cur);
    endfunction
endpackage

// File: rtl/mbox_strobe_sync.sv
module mbox_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic pulse
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], ~strobe_n};
    end

    assign pulse = chain[STAGES-1] & ~chain[STAGES];

    // R9
    one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);
endmodule

// File: rtl/mbox_host_decode.sv
module mbox_host_decode
    import mbox_pkg::*;
(
    input  logic [HOST_AW-1:0] h_addr,
    input  logic               h_aen_n,
    input  logic [BASE_W-1:0]  base_addr,
    output logic               hit,
    output hsel_e              sel
);
    always_comb begin
        hit = !h_aen_n && (h_addr[HOST_AW-1:2] == base_addr);
        sel = hsel_e'(h_addr[1:0]);
    end
endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
    import mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              h_wr_p,
    input  logic              h_rd_p,
    input  logic              h_rd_act,
    input  logic              h_hit,
    input  hsel_e             h_sel,
    input  logic [DW-1:0]     h_wdata,
    input  logic              dma_en,
    input  logic [LOC_AW-1:0] l_addr,
    input  logic              l_rd,
    input  logic              l_wr,
    input  logic [DW-1:0]     l_wdata,
    output logic [DW-1:0]     l_rdata,
    output logic [DW-1:0]     h_rdata,
    output logic [DW-1:0]     aux_q
);
    status_t       st;
    logic [DW-1:0] out0_q, out1_q, in1_q;
    logic          en;
    logic          h_wr_ok, h_rd_ok;
    logic          hw_out0, hw_out1, hw_aux, hr_in1;
    logic          lw_in1, lw_stat, lr_out0, lr_out1;

    always_comb begin
        en      = st.en;
        h_wr_ok = h_wr_p && h_hit && en;
        h_rd_ok = h_rd_p && h_hit && en;
        hw_out0 = h_wr_ok && (h_sel == HSEL_OUT0);
        hw_out1 = h_wr_ok && (h_sel == HSEL_PAIR1);
        hw_aux  = h_wr_ok && (h_sel == HSEL_AUX) && !dma_en;
        hr_in1  = h_rd_ok && (h_sel == HSEL_PAIR1);
        lw_in1  = l_wr && (l_addr == LOFF_PAIR1) && en;
        lw_stat = l_wr && (l_addr == LOFF_STAT);
        lr_out0 = l_rd && (l_addr == LOFF_OUT0) && en;
        lr_out1 = l_rd && (l_addr == LOFF_PAIR1) && en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= '0;
            out0_q <= '0;
            out1_q <= '0;
            in1_q  <= '0;
            aux_q  <= '0;
        end else begin
            if (hw_out0) out0_q <= h_wdata;
            if (hw_out1) out1_q <= h_wdata;
            if (hw_aux)  aux_q  <= h_wdata;
            if (lw_in1)  in1_q  <= l_wdata;
            if (lw_stat) begin
                st.en <= l_wdata[7];
                if (en) st.scratch <= l_wdata[6:4];
            end
            st.out0_dav <= flag_upd(st.out0_dav, hw_out0, lr_out0);
            st.out1_dav <= flag_upd(st.out1_dav, hw_out1, lr_out1);
            st.in1_dav  <= flag_upd(st.in1_dav,  lw_in1,  hr_in1);
            st.rsvd     <= 1'b0;
        end
    end

    always_comb begin
        l_rdata = '0;
        if (en) begin
            case (l_addr)
                LOFF_OUT0:  l_rdata = out0_q;
                LOFF_PAIR1: l_rdata = out1_q;
                LOFF_STAT:  l_rdata = st;
                default:    l_rdata = '0;
            endcase
        end
    end

    always_comb begin
        h_rdata = '0;
        if (en && h_rd_act && h_hit) begin
            case (h_sel)
                HSEL_OUT0:  h_rdata = out0_q;
                HSEL_PAIR1: h_rdata = in1_q;
                HSEL_STAT:  h_rdata = st;
                default:    h_rdata = '0;
            endcase
        end
    end

    // R8
    dav_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !($rose(st.out0_dav) || $rose(st.out1_dav) || $rose(st.in1_dav)));
    // R8
    scratch_lock_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(st.scratch));
    // R7
    aux_hold_chk: assert property (@(posedge clk) disable iff (rst)
        dma_en |=> $stable(aux_q));
    // R5
    in1_set_chk: assert property (@(posedge clk) disable iff (rst)
        lw_in1 |=> st.in1_dav);
    // R3
    out0_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (lr_out0 && !hw_out0) |=> !st.out0_dav);
endmodule

// File: rtl/host_mailbox.sv
module host_mailbox
    import mbox_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [BASE_W-1:0]  base_addr,
    input  logic               dma_mbox_en,
    input  logic [HOST_AW-1:0] h_addr,
    input  logic               h_aen_n,
    input  logic               h_rd_n,
    input  logic               h_wr_n,
    input  logic [DW-1:0]      h_wdata,
    output logic [DW-1:0]      h_rdata,
    input  logic [LOC_AW-1:0]  l_addr,
    input  logic               l_rd,
    input  logic               l_wr,
    input  logic [DW-1:0]      l_wdata,
    output logic [DW-1:0]      l_rdata,
    output logic [DW-1:0]      aux_out
);
    logic  rd_pulse, wr_pulse, hit;
    hsel_e sel;

    mbox_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk(clk), .rst(rst), .strobe_n(h_rd_n), .pulse(rd_pulse));

    mbox_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk(clk), .rst(rst), .strobe_n(h_wr_n), .pulse(wr_pulse));

    mbox_host_decode u_dec (
        .h_addr(h_addr), .h_aen_n(h_aen_n), .base_addr(base_addr),
        .hit(hit), .sel(sel));

    mbox_regs u_regs (
        .clk(clk), .rst(rst),
        .h_wr_p(wr_pulse), .h_rd_p(rd_pulse), .h_rd_act(~h_rd_n),
        .h_hit(hit), .h_sel(sel), .h_wdata(h_wdata),
        .dma_en(dma_mbox_en),
        .l_addr(l_addr), .l_rd(l_rd), .l_wr(l_wr), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .h_rdata(h_rdata), .aux_q(aux_out));
endmodule

// File: tb/host_mailbox_tb.sv
module host_mailbox_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] base_addr = 8'hA5;
    logic       dma_mbox_en = 1'b0;
    logic [9:0] h_addr = '0;
    logic       h_aen_n = 1'b1, h_rd_n = 1'b1, h_wr_n = 1'b1;
    logic [7:0] h_wdata = '0;
    logic [7:0] h_rdata;
    logic [3:0] l_addr = '0;
    logic       l_rd = 1'b0, l_wr = 1'b0;
    logic [7:0] l_wdata = '0;
    logic [7:0] l_rdata;
    logic [7:0] aux_out;

    int n_chk = 0, n_fail = 0;

    // reference model
    logic [7:0] m_out0 = 0, m_out1 = 0, m_in1 = 0, m_aux = 0;
    logic       m_en = 0, m_d0 = 0, m_d1 = 0, m_d3 = 0;
    logic [2:0] m_scr = 0;

    always #10 clk = ~clk;

    host_mailbox u_dut (.*);

    function automatic logic [7:0] exp_status();
        return {m_en, m_scr, m_d3, m_d1, m_d0, 1'b0};
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic host_wr(input logic [9:0] a, input logic aen_n, input logic [7:0] d);
        logic hit;
        hit = !aen_n && a[9:2] == base_addr && m_en;
        @(negedge clk); h_addr = a; h_aen_n = aen_n; h_wdata = d; h_wr_n = 1'b0;
        repeat (5) @(negedge clk);
        h_wr_n = 1'b1;
        repeat (4) @(negedge clk);
        h_aen_n = 1'b1;
        if (hit) begin
            case (a[1:0])
                2'b00: begin m_out0 = d; m_d0 = 1; end
                2'b01: begin m_out1 = d; m_d1 = 1; end
                2'b11: if (!dma_mbox_en) m_aux = d;
                default: ;
            endcase
        end
    endtask

    task automatic host_rd(input logic [9:0] a, input logic aen_n, input string tag);
        logic hit;
        logic [7:0] e;
        hit = !aen_n && a[9:2] == base_addr && m_en;
        e = 8'h00;
        if (hit) begin
            case (a[1:0])
                2'b00: e = m_out0;
                2'b01: e = m_in1;
                2'b10: e = exp_status();
                default: e = 8'h00;
            endcase
        end
        @(negedge clk); h_addr = a; h_aen_n = aen_n; h_rd_n = 1'b0;
        repeat (5) @(negedge clk);
        check(tag, h_rdata, e);
        h_rd_n = 1'b1;
        repeat (4) @(negedge clk);
        h_aen_n = 1'b1;
        if (hit && a[1:0] == 2'b01) m_d3 = 0;
    endtask

    task automatic local_wr(input logic [3:0] off, input logic [7:0] d);
        @(negedge clk); l_addr = off; l_wdata = d; l_wr = 1'b1;
        @(negedge clk); l_wr = 1'b0;
        if (off == 4'h4 && m_en) begin m_in1 = d; m_d3 = 1; end
        if (off == 4'h5) begin
            if (m_en) m_scr = d[6:4];
            m_en = d[7];
        end
    endtask

    task automatic local_rd(input logic [3:0] off, input string tag);
        logic [7:0] e;
        e = 8'h00;
        if (m_en) begin
            case (off)
                4'h3: e = m_out0;
                4'h4: e = m_out1;
                4'h5: e = exp_status();
                default: e = 8'h00;
            endcase
        end
        @(negedge clk); l_addr = off; l_rd = 1'b1;
        #1 check(tag, l_rdata, e);
        @(negedge clk); l_rd = 1'b0;
        if (m_en && off == 4'h3) m_d0 = 0;
        if (m_en && off == 4'h4) m_d1 = 0;
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 aux", aux_out, 8'h00);
        check("R1 hrd", h_rdata, 8'h00);
        // R8 while disabled
        host_wr({8'hA5, 2'b00}, 1'b0, 8'h3C);
        local_wr(4'h4, 8'h77);
        local_wr(4'h5, 8'h70);
        local_rd(4'h5, "R8 stat read blocked");
        host_rd({8'hA5, 2'b10}, 1'b0, "R8 host blocked");
        local_wr(4'h5, 8'h80);
        local_rd(4'h5, "R1 status after enable");
        local_rd(4'h3, "R8 out0 untouched");
        host_rd({8'hA5, 2'b01}, 1'b0, "R8 in1 untouched");
        // R3
        host_wr({8'hA5, 2'b00}, 1'b0, 8'h5A);
        local_rd(4'h5, "R3 flag set");
        host_rd({8'hA5, 2'b00}, 1'b0, "R3 host readback");
        local_rd(4'h3, "R3 local read");
        local_rd(4'h5, "R3 flag cleared");
        // R4
        host_wr({8'hA5, 2'b01}, 1'b0, 8'hC3);
        local_rd(4'h5, "R4 flag set");
        local_rd(4'h4, "R4 local read");
        local_rd(4'h5, "R4 flag cleared");
        // R5
        local_wr(4'h4, 8'h9E);
        local_rd(4'h5, "R5 flag set");
        host_rd({8'hA5, 2'b01}, 1'b0, "R5 host read");
        local_rd(4'h5, "R5 flag cleared");
        // R10 / R6
        local_wr(4'h5, 8'hDF);
        local_rd(4'h5, "R10 scratch written");
        host_wr({8'hA5, 2'b10}, 1'b0, 8'h0F);
        host_rd({8'hA5, 2'b10}, 1'b0, "R6 host status");
        local_rd(4'h7, "R10 unused offset");
        // R2
        host_wr({8'h5A, 2'b00}, 1'b0, 8'h11);
        host_wr({8'hA5, 2'b00}, 1'b1, 8'h22);
        local_rd(4'h5, "R2 no decode");
        host_rd({8'hA4, 2'b10}, 1'b0, "R2 base mismatch");
        // R7
        host_wr({8'hA5, 2'b11}, 1'b0, 8'h6B);
        check("R7 aux latched", aux_out, m_aux);
        dma_mbox_en = 1'b1;
        host_wr({8'hA5, 2'b11}, 1'b0, 8'h94);
        check("R7 aux held", aux_out, m_aux);
        dma_mbox_en = 1'b0;
        host_rd({8'hA5, 2'b11}, 1'b0, "R7 aux read");
        local_rd(4'h5, "R7 no side effect");
        // R9 collision: set and clear of in1 flag in one cycle
        local_wr(4'h4, 8'h11);
        @(negedge clk); h_addr = {8'hA5, 2'b01}; h_aen_n = 1'b0; h_rd_n = 1'b0;
        @(negedge clk);
        @(negedge clk); l_addr = 4'h4; l_wdata = 8'h22; l_wr = 1'b1;
        @(negedge clk); l_wr = 1'b0;
        repeat (3) @(negedge clk); h_rd_n = 1'b1;
        repeat (4) @(negedge clk); h_aen_n = 1'b1;
        m_in1 = 8'h22; m_d3 = 1;
        local_rd(4'h5, "R9 set wins");
        // R9 long strobe yields one action
        @(negedge clk); h_addr = {8'hA5, 2'b00}; h_aen_n = 1'b0; h_wdata = 8'hE1; h_wr_n = 1'b0;
        repeat (5) @(negedge clk);
        m_out0 = 8'hE1; m_d0 = 1;
        local_rd(4'h3, "R9 mid strobe read");
        repeat (12) @(negedge clk); h_wr_n = 1'b1;
        repeat (4) @(negedge clk); h_aen_n = 1'b1;
        local_rd(4'h5, "R9 single action");
        // random phase
        for (int i = 0; i < 400; i++) begin
            logic [9:0] a;
            logic       an;
            a  = {($urandom_range(0, 7) == 0) ? 8'(base_addr ^ 8'h01) : base_addr, 2'($urandom_range(0, 3))};
            an = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 15) == 0) dma_mbox_en = ~dma_mbox_en;
            case ($urandom_range(0, 5))
                0: host_wr(a, an, 8'($urandom));
                1: host_rd(a, an, "R2 random host read");
                2: local_wr(4'h4, 8'($urandom));
                3: local_wr(4'h5, {($urandom_range(0, 7) != 0), 7'($urandom)});
                default: local_rd(4'($urandom_range(3, 5)), "R6 random local read");
            endcase
            check("R7 random aux", aux_out, m_aux);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule